// File: doc/BRIEF.md
# SDIO Receive Byte FIFO with Threshold Interrupt

This block buffers the bytes an SDIO PHY receives from the host before a DMA engine moves them to memory. The PHY issues one write command per byte. Each command carries a target address and a data byte. Only address 0x00 stores data in the FIFO, and every command gets a one-cycle response whether or not it was stored. The DMA drains the FIFO through a valid/ready read port in arrival order.

Software sees the current fill level on `level_o`. It controls two interrupts through a small register write port. The fill interrupt fires once the level reaches a programmable threshold, and software can mask it while a DMA copy is in flight. The PHY reports the CRC result of each block or byte transaction on a status strobe, and a failed check latches a sticky error flag that drives a second interrupt. A write that reaches a full FIFO is dropped and latches a sticky overflow flag. Both flags are cleared by writing one to them.

Top module: `sdio_rx_fifo`

## Requirements
- R1: After reset, `level_o` is 0 and `rd_valid`, `cmd_resp`, `irq_fill`, `irq_crc`, `crc_err_o` and `ovf_o` are all 0. The threshold resets to 1 and the mask resets to clear.
- R2: Every cycle with `cmd_valid` high is followed, in the next cycle, by `cmd_resp` high. This holds for every address and also when the FIFO is full.
- R3: A command to address 0x00 while the FIFO is not full stores `cmd_data`, and `level_o` rises by one in the next cycle.
- R4: A command to any address other than 0x00 stores nothing and leaves `level_o` unchanged.
- R5: `rd_valid` is high exactly when `level_o` is non-zero. `rd_data` shows the oldest byte, bytes leave in arrival order, and each cycle with `rd_valid && rd_ready` removes one byte.
- R6: A store and a removal in the same cycle leave `level_o` unchanged.
- R7: A command to 0x00 while `level_o` equals DEPTH is dropped. The level stays at DEPTH and `ovf_o` (flag bit 1) becomes 1 and stays 1.
- R8: Register select 0 holds the fill threshold. `irq_fill` is high while `level_o` is at or above the threshold and the mask is clear. A threshold of 0 acts as 1.
- R9: Register select 1, bit 0 is the fill mask. While it is 1, `irq_fill` is low. Clearing it restores `irq_fill` from level and threshold.
- R10: A cycle with `crc_valid` high and `crc_ok` low sets `crc_err_o` (flag bit 0), and `irq_crc` follows it. A status with `crc_ok` high changes nothing.
- R11: Writing register select 2 clears each flag whose bit in `reg_wdata` is 1 and keeps flags whose bit is 0. A flag being set in the same cycle stays set.
- R12: `level_o` reports the number of stored bytes, from 0 to DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Write command from the PHY this cycle |
| cmd_addr | input | 8 | Command target address; 0x00 is the FIFO |
| cmd_data | input | 8 | Received byte |
| cmd_resp | output | 1 | Command-accept response, one cycle after the command |
| crc_valid | input | 1 | CRC status strobe from the PHY |
| crc_ok | input | 1 | CRC result, 1 = good |
| rd_valid | output | 1 | A byte is available |
| rd_ready | input | 1 | Reader takes the byte |
| rd_data | output | 8 | Oldest stored byte |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 threshold, 1 mask, 2 flags (write one to clear) |
| reg_wdata | input | 8 | Register write data |
| level_o | output | $clog2(DEPTH+1) | Stored byte count |
| irq_fill | output | 1 | Threshold interrupt |
| irq_crc | output | 1 | CRC error interrupt |
| crc_err_o | output | 1 | Sticky CRC error flag |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
A vector table interleaves stores, stores to a foreign address, lone removals and same-cycle store-with-removal. The table separates the level counter's increment, hold and decrement paths and checks the head byte at each removal. Directed runs fill the FIFO to DEPTH and push once more, which separates the full-drop path from normal storing, and then drain the whole FIFO to prove the dropped byte never entered. Threshold values of 0, 3 and 4 tell the at-or-above comparison apart from strict comparison and from the zero-as-one rule. A CRC failure coinciding with a clear write separates set-priority from clear-priority.

// File: rtl/rxq_pkg.sv
// Package: shared constants for the SDIO receive FIFO.
// Assumes: register select is 2 bits wide; flag bit positions are fixed.
package rxq_pkg;
    localparam logic [7:0] FIFO_ADDR = 8'h00;

    typedef enum logic [1:0] {
        SEL_THRESH = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_FLAGS  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam int FLAG_CRC = 0;
    localparam int FLAG_OVF = 1;
endpackage

// File: rtl/rxq_store.sv
// Module: byte storage ring with a level counter.
// Stores on push when not full and removes on pop when not empty; both may
// occur in one cycle. Assumes DEPTH >= 2. Memory holds no reset.
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic [LVL_W-1:0] level_o,
    output logic             full_o,
    output logic             empty_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             do_push, do_pop;

    assign full_o  = (level_o == FULL_LVL);
    assign empty_o = (level_o == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign head_o  = mem[rptr];

    // Write accepted bytes into the ring.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= data_i;
    end

    // Advance pointers and track the level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            level_o <= '0;
        end else begin
            if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level_o <= level_o + 1'b1;
                2'b01:   level_o <= level_o - 1'b1;
                default: level_o <= level_o;
            endcase
        end
    end

    // R12: the level never exceeds the depth.
    a_r12_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= FULL_LVL);
    // R3: an accepted lone push raises the level by one.
    a_r3_push_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full_o && !pop_i) |=> (level_o == $past(level_o) + 1'b1));
    // R6: push and pop together hold the level.
    a_r6_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !full_o && !empty_o) |=> $stable(level_o));
    // R7: a push into a full ring without a pop leaves it full.
    a_r7_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> full_o);
endmodule

// File: rtl/rxq_regs.sv
// Module: threshold, mask and sticky flag registers with interrupt outputs.
// Assumes LVL_W <= 8 so the threshold fits in a register write.
module rxq_regs
    import rxq_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [7:0]       reg_wdata,
    input  logic [LVL_W-1:0] level_i,
    input  logic             crc_fail_i,
    input  logic             ovf_evt_i,
    output logic             irq_fill_o,
    output logic             irq_crc_o,
    output logic             crc_err_o,
    output logic             ovf_o
);
    logic [LVL_W-1:0] thresh;
    logic [LVL_W-1:0] eff_thresh;
    logic             mask;
    logic             clr_crc, clr_ovf;

    assign clr_crc = reg_wr && (reg_sel == SEL_FLAGS) && reg_wdata[FLAG_CRC];
    assign clr_ovf = reg_wr && (reg_sel == SEL_FLAGS) && reg_wdata[FLAG_OVF];

    // Threshold and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thresh <= LVL_W'(1);
            mask   <= 1'b0;
        end else if (reg_wr) begin
            if (reg_sel == SEL_THRESH) thresh <= reg_wdata[LVL_W-1:0];
            if (reg_sel == SEL_MASK)   mask   <= reg_wdata[0];
        end
    end

    // Sticky flags: set has priority over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_err_o <= 1'b0;
            ovf_o     <= 1'b0;
        end else begin
            if (crc_fail_i)   crc_err_o <= 1'b1;
            else if (clr_crc) crc_err_o <= 1'b0;
            if (ovf_evt_i)    ovf_o <= 1'b1;
            else if (clr_ovf) ovf_o <= 1'b0;
        end
    end

    // Interrupt outputs from level, threshold and flags.
    always_comb begin
        eff_thresh = (thresh == '0) ? LVL_W'(1) : thresh;
        irq_fill_o = !mask && (level_i >= eff_thresh);
        irq_crc_o  = crc_err_o;
    end

    // R9: a set mask silences the fill interrupt.
    a_r9_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !irq_fill_o);
    // R10: a CRC failure leaves the error flag set.
    a_r10_crc_set: assert property (@(posedge clk) disable iff (!rst_n)
        crc_fail_i |=> crc_err_o);
    // R8: an empty FIFO never raises the fill interrupt.
    a_r8_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i == '0) |-> !irq_fill_o);
    // R11: without a clear write, a set flag stays set.
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_ovf) |=> ovf_o);
endmodule

// File: rtl/sdio_rx_fifo.sv
// Module: top of the SDIO receive FIFO. Decodes PHY byte-write commands,
// answers each one a cycle later, feeds the storage ring and the registers.
// Assumes at most one command per cycle and DEPTH <= 128.
module sdio_rx_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_addr,
    input  logic [7:0]       cmd_data,
    output logic             cmd_resp,
    input  logic             crc_valid,
    input  logic             crc_ok,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [7:0]       reg_wdata,
    output logic [LVL_W-1:0] level_o,
    output logic             irq_fill,
    output logic             irq_crc,
    output logic             crc_err_o,
    output logic             ovf_o
);
    logic push, pop, full, empty;

    assign push     = cmd_valid && (cmd_addr == FIFO_ADDR);
    assign rd_valid = !empty;
    assign pop      = rd_valid && rd_ready;

    // Command-accept response, one cycle after each command.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_resp <= 1'b0;
        else        cmd_resp <= cmd_valid;
    end

    rxq_store #(.DEPTH(DEPTH), .WIDTH(8)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .data_i  (cmd_data),
        .pop_i   (pop),
        .head_o  (rd_data),
        .level_o (level_o),
        .full_o  (full),
        .empty_o (empty)
    );

    rxq_regs #(.LVL_W(LVL_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .level_i    (level_o),
        .crc_fail_i (crc_valid && !crc_ok),
        .ovf_evt_i  (push && full),
        .irq_fill_o (irq_fill),
        .irq_crc_o  (irq_crc),
        .crc_err_o  (crc_err_o),
        .ovf_o      (ovf_o)
    );

    // R2: each command is answered in the following cycle.
    a_r2_resp: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> cmd_resp);
    // R4: a foreign-address command without a read keeps the level.
    a_r4_foreign: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_addr != FIFO_ADDR && !pop) |=> $stable(level_o));
    // R5: data is offered exactly when bytes are stored.
    a_r5_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == (level_o != '0));
    // R7: a store into a full FIFO raises the overflow flag.
    a_r7_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> ovf_o);
endmodule

// File: tb/sim_sdio_rx_fifo.sv
module sim_sdio_rx_fifo;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int LW     = $clog2(DEPTH + 1);
    localparam int NVEC   = 12;

    // Fields: [34] cmd, [33:26] addr, [25:18] data, [17] pop,
    // [16:9] head expected at pop, [8:1] level after, [0] irq_fill after.
    localparam logic [34:0] VEC [NVEC] = '{
        {1'b1, 8'h00, 8'h11, 1'b0, 8'h00, 8'd1, 1'b0},
        {1'b1, 8'h00, 8'h22, 1'b0, 8'h00, 8'd2, 1'b0},
        {1'b1, 8'h05, 8'h99, 1'b0, 8'h00, 8'd2, 1'b0},
        {1'b1, 8'h00, 8'h33, 1'b0, 8'h00, 8'd3, 1'b1},
        {1'b0, 8'h00, 8'h00, 1'b1, 8'h11, 8'd2, 1'b0},
        {1'b1, 8'h00, 8'h44, 1'b1, 8'h22, 8'd2, 1'b0},
        {1'b0, 8'h00, 8'h00, 1'b1, 8'h33, 8'd1, 1'b0},
        {1'b0, 8'h00, 8'h00, 1'b1, 8'h44, 8'd0, 1'b0},
        {1'b1, 8'h00, 8'h55, 1'b0, 8'h00, 8'd1, 1'b0},
        {1'b1, 8'h00, 8'h66, 1'b0, 8'h00, 8'd2, 1'b0},
        {1'b1, 8'h00, 8'h77, 1'b0, 8'h00, 8'd3, 1'b1},
        {1'b1, 8'hAB, 8'h7F, 1'b0, 8'h00, 8'd3, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, crc_valid = 1'b0, crc_ok = 1'b1;
    logic rd_ready = 1'b0, reg_wr = 1'b0;
    logic [7:0] cmd_addr = '0, cmd_data = '0, reg_wdata = '0;
    logic [1:0] reg_sel = '0;
    logic cmd_resp, rd_valid, irq_fill, irq_crc, crc_err_o, ovf_o;
    logic [7:0] rd_data;
    logic [LW-1:0] level_o;

    int checks = 0, errors = 0;
    bit done = 0;

    sdio_rx_fifo #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .cmd_resp(cmd_resp), .crc_valid(crc_valid),
        .crc_ok(crc_ok), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_data(rd_data), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .level_o(level_o), .irq_fill(irq_fill),
        .irq_crc(irq_crc), .crc_err_o(crc_err_o), .ovf_o(ovf_o)
    );

    always #(PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Called at a negedge: drive one command, settle at the next negedge.
    task automatic send(input logic [7:0] a, input logic [7:0] d);
        cmd_valid = 1'b1; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wreg(input logic [1:0] s, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic take(input string req, input int exp);
        rd_ready = 1'b1;
        chk(req, int'(rd_data), exp);
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 level", int'(level_o), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 irq_fill", int'(irq_fill), 0);
        chk("R1 flags", int'({irq_crc, crc_err_o, ovf_o, cmd_resp}), 0);

        wreg(2'd0, 8'd3);
        for (int i = 0; i < NVEC; i++) begin
            logic [34:0] v;
            v = VEC[i];
            cmd_valid = v[34]; cmd_addr = v[33:26]; cmd_data = v[25:18];
            rd_ready = v[17];
            if (v[17]) chk("R5 head order", int'(rd_data), int'(v[16:9]));
            @(negedge clk);
            cmd_valid = 1'b0; rd_ready = 1'b0;
            // R3 R4 R6 R12: level after each vector
            chk("R3/R4/R6 level", int'(level_o), int'(v[8:1]));
            chk("R8 irq_fill", int'(irq_fill), int'(v[0]));
            if (v[34]) chk("R2 resp", int'(cmd_resp), 1);
        end

        // R9: masking and unmasking at level 3, threshold 3
        wreg(2'd1, 8'd1);
        chk("R9 masked", int'(irq_fill), 0);
        wreg(2'd1, 8'd0);
        chk("R9 unmasked", int'(irq_fill), 1);
        // R8: threshold above level, then zero acting as one
        wreg(2'd0, 8'd4);
        chk("R8 thr4", int'(irq_fill), 0);
        wreg(2'd0, 8'd0);
        chk("R8 thr0", int'(irq_fill), 1);
        take("R5 drain", 8'h55);
        take("R5 drain", 8'h66);
        take("R5 drain", 8'h77);
        chk("R5 empty valid", int'(rd_valid), 0);
        chk("R8 thr0 empty", int'(irq_fill), 0);

        // R7: fill to depth, then one more store is dropped
        for (int i = 0; i < DEPTH; i++) send(8'h00, 8'(i + 8'h20));
        chk("R12 full level", int'(level_o), DEPTH);
        chk("R7 ovf before", int'(ovf_o), 0);
        send(8'h00, 8'hEE);
        chk("R7 full level", int'(level_o), DEPTH);
        chk("R7 ovf", int'(ovf_o), 1);
        chk("R2 resp full", int'(cmd_resp), 1);
        for (int i = 0; i < DEPTH; i++) take("R7 contents", i + 8'h20);
        chk("R7 no extra", int'(rd_valid), 0);

        // R11: zero write keeps, one write clears
        wreg(2'd2, 8'h01);
        chk("R11 keep ovf", int'(ovf_o), 1);
        wreg(2'd2, 8'h02);
        chk("R11 clear ovf", int'(ovf_o), 0);

        // R10: CRC status
        crc_valid = 1'b1; crc_ok = 1'b1;
        @(negedge clk);
        crc_valid = 1'b0;
        chk("R10 crc ok", int'(crc_err_o), 0);
        crc_valid = 1'b1; crc_ok = 1'b0;
        @(negedge clk);
        crc_valid = 1'b0; crc_ok = 1'b1;
        chk("R10 crc err", int'(crc_err_o), 1);
        chk("R10 irq_crc", int'(irq_crc), 1);
        // R11: set wins over a same-cycle clear
        crc_valid = 1'b1; crc_ok = 1'b0;
        wreg(2'd2, 8'h01);
        crc_valid = 1'b0; crc_ok = 1'b1;
        chk("R11 set wins", int'(crc_err_o), 1);
        wreg(2'd2, 8'h01);
        chk("R11 clear crc", int'(crc_err_o), 0);
        chk("R10 irq_crc low", int'(irq_crc), 0);

        // R1: reset in the middle of activity
        send(8'h00, 8'h01);
        send(8'h00, 8'h02);
        crc_valid = 1'b1; crc_ok = 1'b0;
        @(negedge clk);
        crc_valid = 1'b0; crc_ok = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 mid level", int'(level_o), 0);
        chk("R1 mid flags", int'({rd_valid, irq_fill, crc_err_o}), 0);

        finish_run();
    end
endmodule